// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block picks the clock source that drives a small processor while it is running. There are three candidates: the primary crystal oscillator (which may feed a PLL), a low-speed secondary oscillator that is assumed to be always running, and an internal RC oscillator bank whose output frequency is picked by a small field. Software writes a two-bit source code. The controller then enables and qualifies the primary oscillator and the PLL where needed. It moves the glitch-free clock multiplexer select only when the new source is ready, and it reports whether the primary oscillator is stable.

The oscillators and the gating cells are not modelled here. Everything runs in one reference clock domain. The primary oscillator is seen as a one-cycle tick per oscillator period. A switch to the primary source first counts a start-up number of these ticks. If the PLL was requested, it then waits a lock interval counted in reference cycles. Last, it runs a short changeover count before the select moves. The busy output covers the whole sequence. A new source write during a sequence drops the pending sequence and starts over for the new source. A write to the RC frequency field is applied at once, whether or not a switch is in progress.

Top module: `clksw_switch_ctrl`

## Requirements
- R1: The source code sel_data is decoded as 00 = primary, 01 = secondary, and 1x = internal RC, so bit 0 is ignored when bit 1 is set. The clk_sel output uses 00 = primary, 01 = secondary and 10 = internal RC, and it never shows 11.
- R2: While rst_n is low, the outputs are: clk_sel = 00, busy = 1, osc_stable = 0, pri_osc_en = 1, pll_en = PLL_AT_RESET, rc_freq = FREQ_RESET.
- R3: The primary start-up count begins with the first clock edge after reset is released, or the first edge after a source write that needs it. That write is a primary write when the primary is not already stable with the same PLL request. The count advances only on edges where pri_tick is high, and it completes on the OST_COUNT-th tick. Without the PLL, osc_stable rises on that same edge.
- R4: When pll_req was 1 on the primary write, osc_stable rises exactly LOCK_CYCLES edges after the start-up count completes.
- R5: busy rises on the edge that samples a source write. It falls, and clk_sel takes the new code, exactly SYNC_CYCLES edges after the new source is ready. The source is ready at the write edge for the secondary and RC sources, and for a primary that is already stable with an unchanged PLL request. Otherwise it is ready when osc_stable rises.
- R6: clk_sel holds its old value while busy is high and changes only on the edge where busy falls.
- R7: When a switch to the secondary or RC source completes, pri_osc_en, pll_en and osc_stable are all 0 from that edge on.
- R8: A freq_wr pulse loads freq_val into rc_freq on the next edge, even while busy is high.
- R9: A source write while busy is high drops the pending start-up, lock or changeover count. The sequence restarts from zero for the new source, and clk_sel keeps its old value.
- R10: On a primary write that needs start-up, pri_osc_en is 1 and pll_en equals pll_req. pll_en is never 1 while pri_osc_en is 0, and osc_stable is never 1 while pri_osc_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Source code write strobe |
| sel_data | input | 2 | Source code written with sel_wr |
| pll_req | input | 1 | Route the primary through the PLL (taken on primary writes) |
| freq_wr | input | 1 | RC frequency field write strobe |
| freq_val | input | FREQ_W | RC frequency value |
| pri_tick | input | 1 | One pulse per primary oscillator period |
| pri_osc_en | output | 1 | Primary oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 2 | Glitch-free clock mux select |
| osc_stable | output | 1 | Primary oscillator start-up (and lock) complete |
| busy | output | 1 | Switch sequence in progress |
| rc_freq | output | FREQ_W | Applied RC frequency select |

## Verification
Primary switches are driven with tick periods of one, two and three reference cycles. This separates a count of oscillator ticks from a count of reference cycles. Each tick period is run with and without the PLL, which tells apart a missing or an extra lock wait. Secondary and RC targets, including code 11, show the short changeover path and that the primary is shut down. A repeated primary write while the primary is already stable shows that no fresh start-up is run. Aborts part way into a start-up or a changeover show that the counts restart from zero rather than carry over. An RC frequency write in the middle of every sequence shows that it is not held back by busy.

// File: rtl/clksw_pkg.sv
// Shared types for the run-mode clock source switch controller.
// Assumes: the source code fits two bits and bit 1 set means internal RC.
package clksw_pkg;

    // Clock mux select encoding (also the decoded target source)
    typedef enum logic [1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_RC  = 2'b10
    } clk_src_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OST  = 2'd1,
        ST_LOCK = 2'd2,
        ST_CHG  = 2'd3
    } seq_state_e;

    // Phase indices into the counter bank
    localparam int unsigned PH_OST  = 0;
    localparam int unsigned PH_LOCK = 1;
    localparam int unsigned PH_CHG  = 2;
    localparam int unsigned NUM_PH  = 3;

    // Decode a written source code; the low bit is ignored when RC is chosen
    function automatic clk_src_e decode_src(input logic [1:0] code);
        if (code[1])      return SRC_RC;
        else if (code[0]) return SRC_SEC;
        else              return SRC_PRI;
    endfunction

endpackage

// File: rtl/clksw_interval_counter.sv
// Counts qualified events up to LIMIT and flags the event that completes it.
// Assumes: LIMIT >= 1; clear has priority and holds the count at zero.
// done is combinational and is valid only in a cycle where step is high.
module clksw_interval_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Completion flag: the step that lands on the last count value
    always_comb begin
        done = !clear && step && (cnt == LAST);
    end

    // Event counter, wraps to zero on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/clksw_seq_fsm.sv
// Switch sequencer: takes source writes and phase-complete flags, and
// drives the oscillator/PLL enables, the stable flag and the mux select.
// Assumes: phase_done[] comes from counters that are cleared whenever
// their phase is not active or a write arrives; a write always wins.
module clksw_seq_fsm
    import clksw_pkg::*;
#(
    parameter bit PLL_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [1:0]        sel_data,
    input  logic              pll_req,
    input  logic [NUM_PH-1:0] phase_done,
    output seq_state_e        state,
    output logic              pri_osc_en,
    output logic              pll_en,
    output logic              osc_stable,
    output clk_src_e          clk_sel
);
    clk_src_e wr_src;
    clk_src_e target;
    logic     pll_cfg;
    logic     pri_short;

    // Decode the written code; a primary write can skip start-up when
    // the primary is already stable with the same PLL setting
    always_comb begin
        wr_src    = decode_src(sel_data);
        pri_short = osc_stable && (pll_req == pll_cfg);
    end

    // Sequencer state, enables and mux select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OST;
            target     <= SRC_PRI;
            pll_cfg    <= PLL_AT_RESET;
            pri_osc_en <= 1'b1;
            pll_en     <= PLL_AT_RESET;
            osc_stable <= 1'b0;
            clk_sel    <= SRC_PRI;
        end else if (sel_wr) begin
            target <= wr_src;
            if (wr_src == SRC_PRI) begin
                pll_cfg <= pll_req;
                if (pri_short) begin
                    state <= ST_CHG;
                end else begin
                    state      <= ST_OST;
                    pri_osc_en <= 1'b1;
                    pll_en     <= pll_req;
                    osc_stable <= 1'b0;
                end
            end else begin
                state <= ST_CHG;
            end
        end else begin
            case (state)
                ST_OST: begin
                    if (phase_done[PH_OST]) begin
                        if (pll_cfg) begin
                            state <= ST_LOCK;
                        end else begin
                            osc_stable <= 1'b1;
                            state      <= ST_CHG;
                        end
                    end
                end
                ST_LOCK: begin
                    if (phase_done[PH_LOCK]) begin
                        osc_stable <= 1'b1;
                        state      <= ST_CHG;
                    end
                end
                ST_CHG: begin
                    if (phase_done[PH_CHG]) begin
                        clk_sel <= target;
                        state   <= ST_IDLE;
                        if (target != SRC_PRI) begin
                            pri_osc_en <= 1'b0;
                            pll_en     <= 1'b0;
                            osc_stable <= 1'b0;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/clksw_switch_ctrl.sv
// Top of the run-mode clock source switch controller.
// Holds a bank of three interval counters (start-up ticks, PLL lock
// cycles, changeover cycles), the sequencer and the RC frequency register.
// Assumes: pri_tick is a one-cycle pulse per primary oscillator period,
// already synchronised to clk; the secondary oscillator is always running.
module clksw_switch_ctrl
    import clksw_pkg::*;
#(
    parameter int unsigned OST_COUNT    = 1024,
    parameter int unsigned LOCK_CYCLES  = 32000,
    parameter int unsigned SYNC_CYCLES  = 3,
    parameter int unsigned FREQ_W       = 3,
    parameter logic [FREQ_W-1:0] FREQ_RESET = FREQ_W'(6),
    parameter bit          PLL_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [1:0]        sel_data,
    input  logic              pll_req,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_val,
    input  logic              pri_tick,
    output logic              pri_osc_en,
    output logic              pll_en,
    output logic [1:0]        clk_sel,
    output logic              osc_stable,
    output logic              busy,
    output logic [FREQ_W-1:0] rc_freq
);
    seq_state_e        state;
    clk_src_e          sel_src;
    logic [NUM_PH-1:0] ph_active;
    logic [NUM_PH-1:0] ph_step;
    logic [NUM_PH-1:0] ph_done;

    // Phase activity and step qualifiers for the counter bank
    always_comb begin
        ph_active[PH_OST]  = (state == ST_OST);
        ph_active[PH_LOCK] = (state == ST_LOCK);
        ph_active[PH_CHG]  = (state == ST_CHG);
        ph_step[PH_OST]    = pri_tick;
        ph_step[PH_LOCK]   = 1'b1;
        ph_step[PH_CHG]    = 1'b1;
    end

    // One interval counter per phase; a write restarts every phase
    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        localparam int unsigned LIM = (g == PH_OST)  ? OST_COUNT :
                                      (g == PH_LOCK) ? LOCK_CYCLES :
                                                       SYNC_CYCLES;
        clksw_interval_counter #(
            .LIMIT (LIM)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (!ph_active[g] || sel_wr),
            .step  (ph_step[g]),
            .done  (ph_done[g])
        );
    end

    clksw_seq_fsm #(
        .PLL_AT_RESET (PLL_AT_RESET)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel_data   (sel_data),
        .pll_req    (pll_req),
        .phase_done (ph_done),
        .state      (state),
        .pri_osc_en (pri_osc_en),
        .pll_en     (pll_en),
        .osc_stable (osc_stable),
        .clk_sel    (sel_src)
    );

    // Output view of the sequencer
    always_comb begin
        clk_sel = sel_src;
        busy    = (state != ST_IDLE);
    end

    // RC frequency select: applied directly, independent of any switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_freq <= FREQ_RESET;
        end else if (freq_wr) begin
            rc_freq <= freq_val;
        end
    end

endmodule

// File: rtl/clksw_switch_ctrl_chk.sv
// Port-level property checker for clksw_switch_ctrl, bound to every instance.
module clksw_switch_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] clk_sel,
    input logic       busy,
    input logic       osc_stable,
    input logic       pri_osc_en,
    input logic       pll_en
);
    // R1: the select never carries the unused code
    a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel != 2'b11);

    // R6: the select moves only on the edge where busy falls
    a_r6_sel_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> $fell(busy));

    // R7: with a non-primary source settled, the primary is off and not stable
    a_r7_alt_primary_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && clk_sel != 2'b00) |-> (!pri_osc_en && !pll_en && !osc_stable));

    // R10: the PLL is never enabled without the primary oscillator
    a_r10_pll_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> pri_osc_en);

    // R10: stable is never reported for a disabled oscillator
    a_r10_stable_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stable |-> pri_osc_en);

    // R5: the stable flag rises only inside a switch sequence
    a_r5_stable_rise_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stable) |-> busy);

endmodule

bind clksw_switch_ctrl clksw_switch_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .busy       (busy),
    .osc_stable (osc_stable),
    .pri_osc_en (pri_osc_en),
    .pll_en     (pll_en)
);

// File: tb/sim_clksw_switch_ctrl.sv
`timescale 1ns/1ps
module sim_clksw_switch_ctrl;
    localparam int OST  = 20;
    localparam int LOCK = 24;
    localparam int SYNC = 3;
    localparam int FW   = 3;
    localparam logic [FW-1:0] FRST = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_wr = 1'b0;
    logic [1:0]    sel_data = 2'b00;
    logic          pll_req = 1'b0;
    logic          freq_wr = 1'b0;
    logic [FW-1:0] freq_val = '0;
    logic          pri_tick = 1'b0;
    logic          pri_osc_en, pll_en, osc_stable, busy;
    logic [1:0]    clk_sel;
    logic [FW-1:0] rc_freq;

    int errs = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    // Bench model of the settled state
    int cur_sel = 0;
    bit pri_stable = 1'b0;
    bit cur_pll = 1'b0;

    always #2.5 clk = ~clk;

    clksw_switch_ctrl #(
        .OST_COUNT   (OST),
        .LOCK_CYCLES (LOCK),
        .SYNC_CYCLES (SYNC),
        .FREQ_W      (FW),
        .FREQ_RESET  (FRST),
        .PLL_AT_RESET(1'b0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
        .pll_req(pll_req), .freq_wr(freq_wr), .freq_val(freq_val),
        .pri_tick(pri_tick), .pri_osc_en(pri_osc_en), .pll_en(pll_en),
        .clk_sel(clk_sel), .osc_stable(osc_stable), .busy(busy),
        .rc_freq(rc_freq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tgt_code(input logic [1:0] d);
        return d[1] ? 2 : (d[0] ? 1 : 0);
    endfunction

    function automatic bit needs_startup(input int tgt, input bit pll);
        return (tgt == 0) && !(pri_stable && pll == cur_pll);
    endfunction

    // Expected edges from the write edge until busy falls
    function automatic int exp_busy_edges(input bit long_path, input bit pll, input int p);
        return long_path ? (p * OST + (pll ? LOCK : 0) + SYNC) : SYNC;
    endfunction

    // Source write that is later aborted after k edges
    task automatic abort_write(input logic [1:0] d, input bit pll, input int k);
        int tgt;
        int bad;
        tgt = tgt_code(d);
        bad = 0;
        @(negedge clk);
        sel_wr = 1'b1; sel_data = d; pll_req = pll;
        for (int c = 1; c <= k; c++) begin
            @(negedge clk);
            sel_wr = 1'b0;
            pri_tick = 1'b1;
            if (!busy || clk_sel != 2'(cur_sel)) bad++;
        end
        pri_tick = 1'b0;
        chk(bad == 0, "R9", "busy/select during aborted switch", bad, 0);
        if (tgt == 0) begin
            if (needs_startup(tgt, pll)) pri_stable = 1'b0;
            cur_pll = pll;
        end
    endtask

    // Full switch with measurement; use_rst measures the start-up after reset
    task automatic run_switch(input logic [1:0] d, input bit pll, input int p,
                              input bit use_rst);
        int tgt, old_sel, exp_b, exp_s, busy_at, stab_at, bad, c;
        bit long_path;
        logic [FW-1:0] fv;
        tgt = tgt_code(d);
        old_sel = cur_sel;
        long_path = use_rst ? 1'b1 : needs_startup(tgt, pll);
        exp_b = exp_busy_edges(long_path, pll, p);
        exp_s = p * OST + (pll ? LOCK : 0);
        busy_at = -1; stab_at = -1; bad = 0;
        fv = FW'($urandom);
        @(negedge clk);
        if (!use_rst) begin
            sel_wr = 1'b1; sel_data = d; pll_req = pll;
        end
        c = 0;
        while (busy_at < 0 && c < 4000) begin
            @(negedge clk);
            c++;
            sel_wr = 1'b0;
            freq_wr = 1'b0;
            if (use_rst && c == 1) rst_n = 1'b1;
            pri_tick = ((c % p) == 0);
            if (c == 1) chk(busy == 1'b1, "R5", "busy after write edge", int'(busy), 1);
            if (c == 2) begin
                freq_wr = 1'b1; freq_val = fv;
            end
            if (c == 3) chk(rc_freq == fv, "R8", "rc_freq while busy", int'(rc_freq), int'(fv));
            if (long_path && stab_at < 0 && osc_stable) stab_at = c - 1;
            if (busy && clk_sel != 2'(old_sel)) bad++;
            if (!busy) busy_at = c - 1;
        end
        pri_tick = 1'b0;
        chk(busy_at == exp_b, "R5", "busy length", busy_at, exp_b);
        if (long_path)
            chk(stab_at == exp_s, pll ? "R4" : "R3", "edges to osc_stable", stab_at, exp_s);
        chk(bad == 0, "R6", "select moved while busy", bad, 0);
        chk(clk_sel == 2'(tgt), "R1", "final clk_sel", int'(clk_sel), tgt);
        if (tgt != 0) begin
            chk({pri_osc_en, pll_en, osc_stable} == 3'b000, "R7",
                "primary off after alt switch", int'({pri_osc_en, pll_en, osc_stable}), 0);
            pri_stable = 1'b0;
        end else begin
            if (long_path) cur_pll = pll;
            chk({pri_osc_en, osc_stable} == 2'b11 && pll_en == cur_pll, "R10",
                "primary enables after primary switch",
                int'({pri_osc_en, pll_en, osc_stable}), int'({1'b1, cur_pll, 1'b1}));
            pri_stable = 1'b1;
        end
        cur_sel = tgt;
    endtask

    // Watchdog
    initial begin
        for (int n = 0; n < 190000; n++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int ok_bits;
        void'($urandom(32'd5813));
        repeat (4) @(negedge clk);
        // R2: reset state
        ok_bits = int'({clk_sel, busy, osc_stable, pri_osc_en, pll_en});
        chk(clk_sel == 2'b00 && busy && !osc_stable && pri_osc_en && !pll_en,
            "R2", "reset outputs", ok_bits, int'({2'b00, 1'b1, 1'b0, 1'b1, 1'b0}));
        chk(rc_freq == FRST, "R2", "reset rc_freq", int'(rc_freq), int'(FRST));
        // R3: start-up count begins right after reset release
        run_switch(2'b00, 1'b0, 2, 1'b1);
        // Directed corners
        run_switch(2'b00, 1'b0, 1, 1'b0);   // R5 short path, already stable
        run_switch(2'b11, 1'b0, 1, 1'b0);   // R1 low bit ignored -> RC
        run_switch(2'b00, 1'b1, 3, 1'b0);   // R4 PLL lock after start-up
        run_switch(2'b01, 1'b0, 1, 1'b0);   // R7 secondary shuts primary
        abort_write(2'b00, 1'b1, OST - 3);  // R9 abort mid start-up
        run_switch(2'b00, 1'b0, 2, 1'b0);
        abort_write(2'b10, 1'b0, 1);        // R9 abort mid changeover
        run_switch(2'b01, 1'b0, 1, 1'b0);
        // Constrained random mix
        for (int i = 0; i < 24; i++) begin
            logic [1:0] d;
            bit pl;
            int pp;
            d  = 2'($urandom % 4);
            pl = 1'($urandom % 2);
            pp = 1 + int'($urandom % 3);
            if (($urandom % 4) == 0) begin
                logic [1:0] d0;
                d0 = 2'($urandom % 4);
                abort_write(d0, 1'($urandom % 2),
                            (tgt_code(d0) == 0) ? 1 + int'($urandom % (OST - 2)) : 1);
            end
            run_switch(d, pl, pp, 1'b0);
        end
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule